// File: doc/BRIEF.md
# Dual-Lane Header-Aligned Package Deserializer

This block takes two serial bit lanes from a pixel sensor. Both lanes are sampled in the system clock domain under one shared bit strobe. It rebuilds fixed-width packages from them. While idle it slides a window over each lane. When both windows hold the programmable Header pattern at the same moment, package alignment locks to that point. After that, a package is cut from each lane every `PKT_W` strobed bits. The two lane packages leave the block side by side as one beat of width `2*PKT_W`, with lane 1 in the upper half.

Each frame is walked through a fixed field order: Header, frame number, data length, hit data, and Trailer. The frame number is split across the lanes, so the beat that carries it is the full 32-bit number with its low half from lane 0. The frame closes when the Trailer pattern sits on both lanes in the data phase.

A Header at a package boundary before any Trailer is reported as a sensor reset, and alignment restarts from it. Two conditions abandon a frame and return the block to idle, each with its own pulse:
- a frame that runs past a package limit;
- a frame that runs past a cycle limit.

Top module: `dual_lane_deser`

## Requirements
- R1: While reset is held and on the first cycle after it, `pkt_vld`, `pkt_sof`, `pkt_eof`, the three error pulses and `pkt_data` are all zero.
- R2: A lane bit is taken only in a cycle with `bit_vld` high, entering at the most significant end of the package (first bit received becomes bit `PKT_W-1`). Bits presented while `bit_vld` is low have no effect on any output.
- R3: In idle, once both lanes' last `PKT_W` strobed bits equal `HDR_PAT`, at any bit offset, one beat is emitted with `pkt_sof`=1 and `pkt_data`={HDR_PAT,HDR_PAT}.
- R4: After a Header beat, every further `PKT_W` strobed bits produce exactly one beat, `pkt_vld` high for a single cycle, with `pkt_data`={lane1 package, lane0 package}.
- R5: The beat after the Header carries the frame number (low half on lane 0, high half on lane 1). The next beat carries the data length. All following beats are hit data until the Trailer.
- R6: In the data phase, a package pair with `TRL_PAT` on both lanes is emitted with `pkt_eof`=1 and returns the block to idle. `TRL_PAT` on only one lane is passed as ordinary data.
- R7: A package pair equal to `HDR_PAT` on both lanes at a package boundary, before the Trailer, pulses `err_resync` for one cycle. It is emitted as a new Header beat with `pkt_sof`=1, and the frame restarts from it.
- R8: When a package after the Header would be number `MAX_PKTS+1` of the frame, `err_overrun` pulses. That package is not emitted, no `pkt_eof` follows, and the block returns to idle.
- R9: If a frame is still open `TIMEOUT` cycles after its Header beat, `err_timeout` pulses exactly `TIMEOUT` cycles after that beat, with no beat in that cycle. The block returns to idle, and a later Header starts a fresh frame.
- R10: `pkt_sof` and `pkt_eof` never rise without `pkt_vld`, never rise together, and at most one error pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_vld | input | 1 | Both lane bits are valid this cycle |
| bit_ch0 | input | 1 | Serial bit of lane 0 |
| bit_ch1 | input | 1 | Serial bit of lane 1 |
| pkt_vld | output | 1 | One-cycle strobe per package pair |
| pkt_data | output | 2*PKT_W | {lane 1 package, lane 0 package} |
| pkt_sof | output | 1 | Beat is a Header |
| pkt_eof | output | 1 | Beat is the Trailer closing the frame |
| err_resync | output | 1 | Header seen again before Trailer |
| err_overrun | output | 1 | Frame exceeded the package limit |
| err_timeout | output | 1 | Frame exceeded the cycle limit |

## Verification
The bench builds the block with 16-bit packages, a package limit of 8 and a cycle limit of 400. The small package limit lets it sweep every legal data length from zero up to the exact boundary, plus the first illegal one. The short cycle limit lets it time the abandon pulse to the exact cycle. Each frame is sent both back-to-back and with idle gaps carrying garbage bits, and one frame starts at an odd bit offset. Beat order, contents and flags are compared against lists built in the bench.

// File: rtl/dlds_pkg.sv
package dlds_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_FNUM = 2'd1,
      PH_DLEN = 2'd2,
      PH_DATA = 2'd3
   } phase_e;

   typedef struct packed {
      logic resync;
      logic overrun;
      logic expired;
   } fault_t;

   localparam int unsigned LANES = 2;

endpackage

// File: rtl/dlds_lane_shift.sv
module dlds_lane_shift #(
   parameter int unsigned W         = 16,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         bit_in,
   output logic [W-1:0] word_o
);

   logic [W-1:0] sr_q;

   generate
      if (MSB_FIRST) begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        sr_q <= '0;
            else if (shift_en) sr_q <= {sr_q[W-2:0], bit_in};
         end
      end else begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        sr_q <= '0;
            else if (shift_en) sr_q <= {bit_in, sr_q[W-1:1]};
         end
      end
   endgenerate

   assign word_o = sr_q;

   // R2: without a strobe the window must not move
   assert_hold_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(sr_q));

endmodule

// File: rtl/dlds_slot_count.sv
module dlds_slot_count #(
   parameter int unsigned W = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic active,
   input  logic tick,
   output logic slot_done
);

   localparam int unsigned CW = (W > 2) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [CW-1:0] cnt_q;

   assign slot_done = active && tick && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (restart || !active) cnt_q <= '0;
      else if (tick)               cnt_q <= slot_done ? '0 : cnt_q + CW'(1);
   end

   // R4: package boundaries are at least one bit apart
   assert_slot_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      slot_done |=> !slot_done);

endmodule

// File: rtl/dlds_frame_timer.sv
module dlds_frame_timer #(
   parameter int unsigned LIMIT = 11520
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   output logic expired
);

   localparam int unsigned TW = $clog2(LIMIT + 1);
   localparam logic [TW-1:0] END_VAL = TW'(LIMIT - 1);

   logic [TW-1:0] cnt_q;

   assign expired = run && (cnt_q == END_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clear || !run)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + TW'(1);
   end

   // R9: the count never passes the limit while a frame is open
   assert_timer_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= END_VAL));

endmodule

// File: rtl/dlds_frame_fsm.sv
module dlds_frame_fsm
   import dlds_pkg::*;
#(
   parameter int unsigned     W        = 16,
   parameter logic [W-1:0]    HDR_PAT  = 16'h5555,
   parameter logic [W-1:0]    TRL_PAT  = 16'h8001,
   parameter int unsigned     MAX_PKTS = 574
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tick,
   input  logic [W-1:0]   word0,
   input  logic [W-1:0]   word1,
   input  logic           slot_done,
   input  logic           expired,
   output logic           active,
   output logic           restart,
   output logic           beat_vld,
   output logic [2*W-1:0] beat_data,
   output logic           beat_sof,
   output logic           beat_eof,
   output fault_t         faults
);

   localparam int unsigned PCW = $clog2(MAX_PKTS + 1);
   localparam logic [PCW-1:0] PKT_LIMIT = PCW'(MAX_PKTS);

   phase_e          phase_q, phase_d;
   logic [PCW-1:0]  pcnt_q, pcnt_d;
   logic            hdr_both, trl_both;
   logic            b_vld, b_sof, b_eof;
   fault_t          flt_d;

   logic            vld_q, sof_q, eof_q;
   logic [2*W-1:0]  data_q;
   fault_t          flt_q;

   assign hdr_both = (word0 == HDR_PAT) && (word1 == HDR_PAT);
   assign trl_both = (word0 == TRL_PAT) && (word1 == TRL_PAT);
   assign active   = (phase_q != PH_IDLE);

   always_comb begin
      phase_d = phase_q;
      pcnt_d  = pcnt_q;
      b_vld   = 1'b0;
      b_sof   = 1'b0;
      b_eof   = 1'b0;
      flt_d   = '0;
      restart = 1'b0;
      if (phase_q == PH_IDLE) begin
         if (tick && hdr_both) begin
            b_vld   = 1'b1;
            b_sof   = 1'b1;
            phase_d = PH_FNUM;
            pcnt_d  = '0;
            restart = 1'b1;
         end
      end else if (expired) begin
         flt_d.expired = 1'b1;
         phase_d       = PH_IDLE;
      end else if (slot_done) begin
         if (hdr_both) begin
            flt_d.resync = 1'b1;
            b_vld        = 1'b1;
            b_sof        = 1'b1;
            phase_d      = PH_FNUM;
            pcnt_d       = '0;
            restart      = 1'b1;
         end else if (pcnt_q == PKT_LIMIT) begin
            flt_d.overrun = 1'b1;
            phase_d       = PH_IDLE;
         end else begin
            b_vld  = 1'b1;
            pcnt_d = pcnt_q + PCW'(1);
            unique case (phase_q)
               PH_FNUM: phase_d = PH_DLEN;
               PH_DLEN: phase_d = PH_DATA;
               PH_DATA: begin
                  if (trl_both) begin
                     b_eof   = 1'b1;
                     phase_d = PH_IDLE;
                  end
               end
               default: phase_d = PH_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         pcnt_q  <= '0;
         vld_q   <= 1'b0;
         sof_q   <= 1'b0;
         eof_q   <= 1'b0;
         data_q  <= '0;
         flt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         pcnt_q  <= pcnt_d;
         vld_q   <= b_vld;
         sof_q   <= b_sof;
         eof_q   <= b_eof;
         flt_q   <= flt_d;
         if (b_vld) data_q <= {word1, word0};
      end
   end

   assign beat_vld  = vld_q;
   assign beat_data = data_q;
   assign beat_sof  = sof_q;
   assign beat_eof  = eof_q;
   assign faults    = flt_q;

   // R6: a closing beat leaves the machine idle
   assert_eof_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      eof_q |-> (phase_q == PH_IDLE));

   // R7: a resync leaves the machine expecting a frame number
   assert_resync_fnum_R7: assert property (@(posedge clk) disable iff (!rst_n)
      flt_q.resync |-> (phase_q == PH_FNUM));

   // R8: an overrun always abandons the frame
   assert_overrun_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flt_q.overrun |-> (phase_q == PH_IDLE));

   // R8: the package count never passes the limit
   assert_pcnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt_q <= PKT_LIMIT);

endmodule

// File: rtl/dual_lane_deser.sv
module dual_lane_deser
   import dlds_pkg::*;
#(
   parameter int unsigned      PKT_W     = 16,
   parameter logic [PKT_W-1:0] HDR_PAT   = 16'h5555,
   parameter logic [PKT_W-1:0] TRL_PAT   = 16'h8001,
   parameter int unsigned      MAX_PKTS  = 574,
   parameter int unsigned      TIMEOUT   = 11520,
   parameter bit               MSB_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_vld,
   input  logic                 bit_ch0,
   input  logic                 bit_ch1,
   output logic                 pkt_vld,
   output logic [2*PKT_W-1:0]   pkt_data,
   output logic                 pkt_sof,
   output logic                 pkt_eof,
   output logic                 err_resync,
   output logic                 err_overrun,
   output logic                 err_timeout
);

   // elaboration-time parameter checks
   generate
      if (PKT_W < 4) begin : g_bad_width
         $error("PKT_W must be at least 4");
      end
      if (MAX_PKTS < 3) begin : g_bad_limit
         $error("MAX_PKTS must cover frame number, length and trailer");
      end
      if (TIMEOUT < 2 * PKT_W) begin : g_bad_timeout
         $error("TIMEOUT must span at least two packages");
      end
      if (HDR_PAT == TRL_PAT) begin : g_bad_patterns
         $error("HDR_PAT and TRL_PAT must differ");
      end
   endgenerate

   logic [LANES-1:0] lane_bits;
   logic [PKT_W-1:0] lane_word [LANES];
   logic             tick_q;
   logic             slot_done, expired, active, restart;
   fault_t           faults;

   assign lane_bits = {bit_ch1, bit_ch0};

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         dlds_lane_shift #(
            .W         (PKT_W),
            .MSB_FIRST (MSB_FIRST)
         ) u_shift (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (bit_vld),
            .bit_in   (lane_bits[g]),
            .word_o   (lane_word[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tick_q <= 1'b0;
      else        tick_q <= bit_vld;
   end

   dlds_slot_count #(.W(PKT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (restart),
      .active    (active),
      .tick      (tick_q),
      .slot_done (slot_done)
   );

   dlds_frame_timer #(.LIMIT(TIMEOUT)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (restart),
      .run     (active),
      .expired (expired)
   );

   dlds_frame_fsm #(
      .W        (PKT_W),
      .HDR_PAT  (HDR_PAT),
      .TRL_PAT  (TRL_PAT),
      .MAX_PKTS (MAX_PKTS)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_q),
      .word0     (lane_word[0]),
      .word1     (lane_word[1]),
      .slot_done (slot_done),
      .expired   (expired),
      .active    (active),
      .restart   (restart),
      .beat_vld  (pkt_vld),
      .beat_data (pkt_data),
      .beat_sof  (pkt_sof),
      .beat_eof  (pkt_eof),
      .faults    (faults)
   );

   assign err_resync  = faults.resync;
   assign err_overrun = faults.overrun;
   assign err_timeout = faults.expired;

   // R4: one-cycle strobe per package pair
   assert_vld_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_vld |=> !pkt_vld);

   // R10: frame flags only ride on a beat
   assert_flag_on_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_sof || pkt_eof) |-> pkt_vld);

   // R10: start and end never share a beat
   assert_sof_eof_apart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(pkt_sof && pkt_eof));

   // R10: at most one error pulse at a time
   assert_one_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_resync, err_overrun, err_timeout}));

   // R8: the overflowing package is dropped
   assert_overrun_no_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_overrun |-> !pkt_vld);

   // R9: an abandoned frame emits nothing in that cycle
   assert_timeout_no_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
      err_timeout |-> !pkt_vld);

endmodule

// File: tb/dual_lane_deser_test.sv
module dual_lane_deser_test;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 16;
   localparam logic [W-1:0] HDR = 16'h5555;
   localparam logic [W-1:0] TRL = 16'h8001;
   localparam int MAXP       = 8;
   localparam int TMO        = 400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_vld = 1'b0;
   logic bit_ch0 = 1'b0;
   logic bit_ch1 = 1'b0;
   logic pkt_vld, pkt_sof, pkt_eof;
   logic [2*W-1:0] pkt_data;
   logic err_resync, err_overrun, err_timeout;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dual_lane_deser #(
      .PKT_W    (W),
      .HDR_PAT  (HDR),
      .TRL_PAT  (TRL),
      .MAX_PKTS (MAXP),
      .TIMEOUT  (TMO)
   ) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_vld     (bit_vld),
      .bit_ch0     (bit_ch0),
      .bit_ch1     (bit_ch1),
      .pkt_vld     (pkt_vld),
      .pkt_data    (pkt_data),
      .pkt_sof     (pkt_sof),
      .pkt_eof     (pkt_eof),
      .err_resync  (err_resync),
      .err_overrun (err_overrun),
      .err_timeout (err_timeout)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   logic [31:0] got_d [64];
   bit          got_s [64];
   bit          got_e [64];
   int          nb = 0;
   logic [31:0] exp_d [64];
   bit          exp_s [64];
   bit          exp_e [64];
   int          ne = 0;
   int          n_rs = 0, n_ov = 0, n_to = 0;
   int          sof_cyc = 0, to_cyc = 0;

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      if (rst_n) begin
         if (pkt_vld) begin
            if (nb < 64) begin
               got_d[nb] = pkt_data;
               got_s[nb] = pkt_sof;
               got_e[nb] = pkt_eof;
            end
            nb++;
            if (pkt_sof) sof_cyc = cyc;
         end
         if (err_resync)  n_rs++;
         if (err_overrun) n_ov++;
         if (err_timeout) begin n_to++; to_cyc = cyc; end
      end
   end

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic clear_all();
      nb = 0; ne = 0; n_rs = 0; n_ov = 0; n_to = 0;
   endtask

   task automatic push(input logic [W-1:0] c0, input logic [W-1:0] c1, input bit s, input bit e);
      exp_d[ne] = {c1, c0};
      exp_s[ne] = s;
      exp_e[ne] = e;
      ne++;
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         bit_vld = 1'b0;
         bit_ch0 = ~bit_ch0;
         bit_ch1 = 1'($urandom_range(0, 1));
      end
   endtask

   task automatic send_bits(input int k, input int gap);
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         bit_vld = 1'b1; bit_ch0 = 1'b0; bit_ch1 = 1'b0;
         if (gap > 0) idle(gap);
      end
   endtask

   task automatic send_pkt(input logic [W-1:0] c0, input logic [W-1:0] c1, input int gap);
      for (int i = W - 1; i >= 0; i--) begin
         @(negedge clk);
         bit_vld = 1'b1;
         bit_ch0 = c0[i];
         bit_ch1 = c1[i];
         if (gap > 0) idle(gap);
      end
   endtask

   task automatic put(input logic [W-1:0] c0, input logic [W-1:0] c1, input bit s, input bit e, input int gap);
      push(c0, c1, s, e);
      send_pkt(c0, c1, gap);
   endtask

   // full frame with n data pairs; pre = zero bits sent before the header
   task automatic frame(input int n, input int gap, input logic [31:0] fnum, input int pre);
      send_bits(pre, gap);
      put(HDR, HDR, 1'b1, 1'b0, gap);
      put(fnum[15:0], fnum[31:16], 1'b0, 1'b0, gap);
      put(W'(n), W'(n), 1'b0, 1'b0, gap);
      for (int i = 0; i < n; i++) put(W'(16'h1000 + i), W'(16'h2000 + i), 1'b0, 1'b0, gap);
      put(TRL, TRL, 1'b0, 1'b1, gap);
   endtask

   task automatic compare(input string req);
      check({req, " beat count"}, 32'(nb), 32'(ne));
      for (int i = 0; i < ne && i < nb && i < 64; i++) begin
         check({req, " beat data"}, got_d[i], exp_d[i]);
         check({req, " beat sof"}, 32'(got_s[i]), 32'(exp_s[i]));
         check({req, " beat eof"}, 32'(got_e[i]), 32'(exp_e[i]));
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (4) @(negedge clk);
      check("R1 vld", 32'(pkt_vld), 0);
      check("R1 data", pkt_data, 0);
      check("R1 flags", {29'd0, pkt_sof, pkt_eof, 1'b0}, 0);
      check("R1 errs", {29'd0, err_resync, err_overrun, err_timeout}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {27'd0, pkt_vld, pkt_sof, pkt_eof, err_resync, err_timeout}, 0);

      // R2: header bits presented without strobe do nothing
      clear_all();
      for (int i = W - 1; i >= 0; i--) begin
         @(negedge clk); bit_vld = 1'b0; bit_ch0 = HDR[i]; bit_ch1 = HDR[i];
      end
      idle(10);
      check("R2 no strobe no beat", 32'(nb), 0);

      // R3/R4/R5/R6: sweep data length and gap
      for (int gap = 0; gap < 2; gap++) begin
         for (int n = 0; n <= MAXP - 3; n++) begin
            clear_all();
            frame(n, gap, 32'h0003_0000 + 32'(n), W);
            idle(8);
            compare("R3/R4/R5/R6 sweep");
            check("R6 no errors in sweep", 32'(n_rs + n_ov + n_to), 0);
         end
      end

      // R3: header found at an odd bit offset
      clear_all();
      frame(2, 0, 32'h0000_0077, 7);
      idle(8);
      compare("R3 odd offset");

      // R6: trailer on one lane is plain data
      clear_all();
      send_bits(W, 0);
      put(HDR, HDR, 1'b1, 1'b0, 0);
      put(16'h0009, 16'h0000, 1'b0, 1'b0, 0);
      put(16'h0002, 16'h0002, 1'b0, 1'b0, 0);
      put(TRL, 16'h2000, 1'b0, 1'b0, 0);
      put(16'h1234, TRL, 1'b0, 1'b0, 0);
      put(TRL, TRL, 1'b0, 1'b1, 0);
      idle(8);
      compare("R6 single-lane trailer");

      // R7: second header before trailer
      clear_all();
      send_bits(W, 0);
      put(HDR, HDR, 1'b1, 1'b0, 0);
      put(16'h0007, 16'h0000, 1'b0, 1'b0, 0);
      put(16'h0001, 16'h0001, 1'b0, 1'b0, 0);
      put(16'h1000, 16'h2000, 1'b0, 1'b0, 0);
      put(HDR, HDR, 1'b1, 1'b0, 0);
      put(16'h0008, 16'h0000, 1'b0, 1'b0, 0);
      put(16'h0000, 16'h0000, 1'b0, 1'b0, 0);
      put(TRL, TRL, 1'b0, 1'b1, 0);
      idle(8);
      compare("R7 resync");
      check("R7 resync pulses", 32'(n_rs), 1);

      // R8: one package too many
      clear_all();
      send_bits(W, 0);
      put(HDR, HDR, 1'b1, 1'b0, 0);
      put(16'h0005, 16'h0000, 1'b0, 1'b0, 0);
      put(16'h0006, 16'h0006, 1'b0, 1'b0, 0);
      for (int i = 0; i < MAXP - 2; i++) put(W'(16'h1000 + i), W'(16'h2000 + i), 1'b0, 1'b0, 0);
      send_pkt(TRL, TRL, 0);
      idle(8);
      compare("R8 overrun");
      check("R8 overrun pulses", 32'(n_ov), 1);
      clear_all();
      frame(1, 0, 32'h0000_0011, W);
      idle(8);
      compare("R8 recovery");

      // R9: frame stalls after header
      clear_all();
      send_bits(W, 0);
      put(HDR, HDR, 1'b1, 1'b0, 0);
      idle(TMO + 40);
      compare("R9 stalled frame");
      check("R9 timeout pulses", 32'(n_to), 1);
      check("R9 timeout distance", 32'(to_cyc - sof_cyc), 32'(TMO));
      clear_all();
      frame(3, 1, 32'h0000_0022, W);
      idle(8);
      compare("R9 recovery");
      check("R9 no timeout on short frame", 32'(n_to), 0);

      finish_run();
   end

endmodule